// File: doc/BRIEF.md
# Debug Burst Memory Access Engine

This block is the part of a processor debug unit that moves data between a debug host and the target. The host programs four registers through a simple register port: a start address, a data holding register, a repeat count and a mode/control register. When the host sets the start bit, the engine runs a burst of accesses. A write burst takes one item from the inbound stream for each access. A read burst places each value it fetches on the outbound stream.

A burst can go to system memory or to the CPU's sixteen general-purpose registers. Memory accesses are either full 16-bit words or single bytes. The address step depends on the mode. Byte writes drive only the lane that the address selects, so the other byte of the word is left untouched. Byte reads return the selected byte with zeros in the upper bits. The count register holds one less than the number of accesses. The start bit never reads back as set.

Top module: `dbg_burst_engine`

## Requirements
- R1: After reset, all four host registers read 0, and `busy`, `in_ready`, `out_valid`, `mem_en`, `rf_rd` and `rf_wr` are low.
- R2: Register select codes on `cfg_sel` are 0 for address, 1 for data, 2 for count and 3 for control. Address, data and count store and return all 16 bits. Control stores only bits 3:1 and reads bit 0 as 0, so writing 0xFFFE reads back 0x000E.
- R3: Control bits: bit 0 starts a burst, bit 1 selects write (1) or read (0), bit 2 selects the register file (1) or memory (0), and bit 3 selects byte (1) or word (0) width for memory targets. Register-file accesses are always full words.
- R4: A count value of N-1 gives exactly N target accesses, so a count of 0 gives exactly one. `busy` is high from the edge that accepts the start until the edge of the last access. While idle, no target access and no stream handshake signal is asserted.
- R5: Word memory bursts present the byte address on `mem_addr`, drive both byte enables and advance the address by 2 per access.
- R6: Register-file bursts use address bits 3:0 as `rf_idx` and advance the address by 1 per access.
- R7: Byte memory writes take the byte from `in_data[7:0]` and advance the address by 1. An even address enables only lane 0 (`mem_be`=01, bits 7:0). An odd address enables only lane 1 (`mem_be`=10, bits 15:8).
- R8: Byte memory reads return the byte in the lane selected by address bit 0, zero-extended to 16 bits, in address order.
- R9: In a write burst, `in_ready` is high only while the engine waits for an item. Every accepted item causes exactly one target write in the same cycle, and no target write happens without an accepted item.
- R10: In a read burst, each fetched value is shown on `out_data` with `out_valid` high. Both are held unchanged until `out_ready` is high.
- R11: When a burst ends, the address register holds the start address plus the number of accesses times the step, and the count register holds 0. The data register holds the last item moved: a write item as used, zero-extended in byte mode, or the last read value.
- R12: Host register writes, including a new start, are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 2 | Host register select (0 address, 1 data, 2 count, 3 control) |
| cfg_wdata | input | 16 | Host register write value |
| cfg_rdata | output | 16 | Readback of the selected register (combinational) |
| busy | output | 1 | Burst in progress |
| in_valid | input | 1 | Inbound write item valid |
| in_ready | output | 1 | Engine accepts an inbound item |
| in_data | input | 16 | Inbound write item |
| out_valid | output | 1 | Outbound read item valid |
| out_ready | input | 1 | Host accepts the outbound item |
| out_data | output | 16 | Outbound read item |
| mem_en | output | 1 | Memory access strobe |
| mem_wr | output | 1 | Memory access is a write |
| mem_be | output | 2 | Memory byte-lane enables |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read strobe |
| rf_rd | output | 1 | Register-file read strobe |
| rf_wr | output | 1 | Register-file write strobe |
| rf_idx | output | 4 | Register index |
| rf_wdata | output | 16 | Register write data |
| rf_rdata | input | 16 | Register read data, valid the cycle after a read strobe |

## Verification
A wrong count or address update does not show during the burst. It shows at the end: `busy` falls one access early or late, or one item too many or too few is moved, and the final address readback is off. A bad lane choice shows in the very access it affects, as a wrong byte enable or as a neighbouring byte that gets overwritten. On the read side, a mistimed capture shows as the wrong value or a changing value on `out_data` while the host stalls `out_ready`. Checking memory contents after each item, together with the final register readback, narrows each fault to one access.

// File: rtl/dbgb_pkg.sv
package dbgb_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_CTRL  = 2'd3
  } sel_e;

  typedef struct packed {
    logic byte_mode;
    logic to_rf;
    logic is_write;
  } mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WR_WAIT,
    ST_RD_ISSUE,
    ST_RD_CAPT,
    ST_RD_OUT
  } state_e;

endpackage

// File: rtl/dbgb_rst_sync.sv
module dbgb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/dbgb_cfg_regs.sv
module dbgb_cfg_regs
  import dbgb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  sel_e          host_sel,
  input  logic [W-1:0]  host_wdata,
  output logic [W-1:0]  host_rdata,
  input  logic          busy,
  input  logic          adv,
  input  logic [W-1:0]  step,
  input  logic          data_ld,
  input  logic [W-1:0]  load_value,
  output logic [W-1:0]  addr_q,
  output logic [W-1:0]  data_q,
  output mode_t         mode_q,
  output logic          last,
  output logic          start_pulse
);

  logic [W-1:0] count_q;
  logic [W-1:0] addr_n, data_n, count_n;
  mode_t        mode_n;
  logic         host_ok;

  assign host_ok     = host_we && !busy;
  assign start_pulse = host_ok && (host_sel == SEL_CTRL) && host_wdata[0];
  assign last        = (count_q == '0);

  always_comb begin
    addr_n  = addr_q;
    data_n  = data_q;
    count_n = count_q;
    mode_n  = mode_q;
    if (host_ok) begin
      case (host_sel)
        SEL_ADDR:  addr_n  = host_wdata;
        SEL_DATA:  data_n  = host_wdata;
        SEL_COUNT: count_n = host_wdata;
        default:   mode_n  = mode_t'(host_wdata[3:1]);
      endcase
    end
    if (adv) begin
      addr_n = addr_q + step;
      if (!last) count_n = count_q - 1'b1;
    end
    if (data_ld) data_n = load_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      count_q <= '0;
      mode_q  <= '0;
    end else begin
      addr_q  <= addr_n;
      data_q  <= data_n;
      count_q <= count_n;
      mode_q  <= mode_n;
    end
  end

  always_comb begin
    case (host_sel)
      SEL_ADDR:  host_rdata = addr_q;
      SEL_DATA:  host_rdata = data_q;
      SEL_COUNT: host_rdata = count_q;
      default:   host_rdata = W'({mode_q, 1'b0});
    endcase
  end

endmodule

// File: rtl/dbgb_lane.sv
module dbgb_lane
  import dbgb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]      addr,
  input  mode_t             mode,
  input  logic [W-1:0]      in_data,
  input  logic [W-1:0]      src_rdata,
  output logic [W-1:0]      step,
  output logic [W/8-1:0]    be,
  output logic [W-1:0]      wdata,
  output logic [W-1:0]      load_value
);

  localparam int LANES  = W / 8;
  localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic             eff_byte;
  logic [LANES-1:0] lane_hit;
  logic [7:0]       lane_bytes [LANES];
  logic [7:0]       rd_byte;
  logic [W-1:0]     rd_value;

  assign eff_byte = mode.byte_mode && !mode.to_rf;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_hit[g]   = (addr[LSEL_W-1:0] == LSEL_W'(g));
    assign lane_bytes[g] = src_rdata[8*g +: 8];
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_hit[i]) rd_byte = lane_bytes[i];
    end
  end

  assign step     = (eff_byte || mode.to_rf) ? W'(1) : W'(LANES);
  assign be       = eff_byte ? lane_hit : '1;
  assign wdata    = eff_byte ? {LANES{in_data[7:0]}} : in_data;
  assign rd_value = eff_byte ? W'(rd_byte) : src_rdata;

  always_comb begin
    if (mode.is_write) load_value = eff_byte ? W'(in_data[7:0]) : in_data;
    else               load_value = rd_value;
  end

endmodule

// File: rtl/dbgb_seq.sv
module dbgb_seq
  import dbgb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_pulse,
  input  mode_t mode,
  input  logic  last,
  input  logic  in_valid,
  input  logic  out_ready,
  output logic  busy,
  output logic  in_ready,
  output logic  out_valid,
  output logic  issue_rd,
  output logic  issue_wr,
  output logic  data_ld,
  output logic  adv
);

  state_e state_q, state_n;

  always_comb begin
    state_n   = state_q;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    issue_rd  = 1'b0;
    issue_wr  = 1'b0;
    data_ld   = 1'b0;
    adv       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_pulse) state_n = ST_LAUNCH;
      end
      ST_LAUNCH: begin
        state_n = mode.is_write ? ST_WR_WAIT : ST_RD_ISSUE;
      end
      ST_WR_WAIT: begin
        in_ready = 1'b1;
        if (in_valid) begin
          issue_wr = 1'b1;
          data_ld  = 1'b1;
          adv      = 1'b1;
          if (last) state_n = ST_IDLE;
        end
      end
      ST_RD_ISSUE: begin
        issue_rd = 1'b1;
        state_n  = ST_RD_CAPT;
      end
      ST_RD_CAPT: begin
        data_ld = 1'b1;
        state_n = ST_RD_OUT;
      end
      ST_RD_OUT: begin
        out_valid = 1'b1;
        if (out_ready) begin
          adv     = 1'b1;
          state_n = last ? ST_IDLE : ST_RD_ISSUE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/dbg_burst_engine.sv
module dbg_burst_engine
  import dbgb_pkg::*;
#(
  parameter int W        = 16,
  parameter int RF_IDX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [W-1:0]        cfg_wdata,
  output logic [W-1:0]        cfg_rdata,
  output logic                busy,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [W-1:0]        in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [W-1:0]        out_data,
  output logic                mem_en,
  output logic                mem_wr,
  output logic [W/8-1:0]      mem_be,
  output logic [W-1:0]        mem_addr,
  output logic [W-1:0]        mem_wdata,
  input  logic [W-1:0]        mem_rdata,
  output logic                rf_rd,
  output logic                rf_wr,
  output logic [RF_IDX_W-1:0] rf_idx,
  output logic [W-1:0]        rf_wdata,
  input  logic [W-1:0]        rf_rdata
);

  logic         rst_n_sync;
  logic         adv, data_ld, issue_rd, issue_wr, last, start_pulse;
  logic [W-1:0] step, load_value, addr_q, data_q, src_rdata;
  mode_t        mode_q;

  dbgb_rst_sync #(.STAGES(2)) rst_i (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  dbgb_cfg_regs #(.W(W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .host_we     (cfg_we),
    .host_sel    (sel_e'(cfg_sel)),
    .host_wdata  (cfg_wdata),
    .host_rdata  (cfg_rdata),
    .busy        (busy),
    .adv         (adv),
    .step        (step),
    .data_ld     (data_ld),
    .load_value  (load_value),
    .addr_q      (addr_q),
    .data_q      (data_q),
    .mode_q      (mode_q),
    .last        (last),
    .start_pulse (start_pulse)
  );

  assign src_rdata = mode_q.to_rf ? rf_rdata : mem_rdata;

  dbgb_lane #(.W(W)) lane_i (
    .addr       (addr_q),
    .mode       (mode_q),
    .in_data    (in_data),
    .src_rdata  (src_rdata),
    .step       (step),
    .be         (mem_be),
    .wdata      (mem_wdata),
    .load_value (load_value)
  );

  dbgb_seq seq_i (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .start_pulse (start_pulse),
    .mode        (mode_q),
    .last        (last),
    .in_valid    (in_valid),
    .out_ready   (out_ready),
    .busy        (busy),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .issue_rd    (issue_rd),
    .issue_wr    (issue_wr),
    .data_ld     (data_ld),
    .adv         (adv)
  );

  assign mem_en   = (issue_rd || issue_wr) && !mode_q.to_rf;
  assign mem_wr   = issue_wr && !mode_q.to_rf;
  assign mem_addr = addr_q;
  assign rf_rd    = issue_rd && mode_q.to_rf;
  assign rf_wr    = issue_wr && mode_q.to_rf;
  assign rf_idx   = addr_q[RF_IDX_W-1:0];
  assign rf_wdata = in_data;
  assign out_data = data_q;

endmodule

// File: rtl/dbgb_checker.sv
module dbgb_checker #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     cfg_sel,
  input logic [W-1:0]   cfg_rdata,
  input logic           busy,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [W-1:0]   out_data,
  input logic           mem_en,
  input logic           mem_wr,
  input logic [W/8-1:0] mem_be,
  input logic [W-1:0]   mem_addr,
  input logic           rf_rd,
  input logic           rf_wr
);

  localparam int LSEL_W = (W / 8 > 1) ? $clog2(W / 8) : 1;

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_en || rf_rd || rf_wr || in_ready || out_valid));

  a_r9_write_needs_item: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_en && mem_wr) || rf_wr) |-> (in_valid && in_ready));

  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r7_single_lane_matches_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_wr && $countones(mem_be) == 1) |-> mem_be[mem_addr[LSEL_W-1:0]]);

  a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_en && (rf_rd || rf_wr)) && !(rf_rd && rf_wr));

  a_r2_start_bit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'd3) |-> (cfg_rdata[0] == 1'b0));

endmodule

bind dbg_burst_engine dbgb_checker #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_sel   (cfg_sel),
  .cfg_rdata (cfg_rdata),
  .busy      (busy),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .mem_en    (mem_en),
  .mem_wr    (mem_wr),
  .mem_be    (mem_be),
  .mem_addr  (mem_addr),
  .rf_rd     (rf_rd),
  .rf_wr     (rf_wr)
);

// File: tb/dbg_burst_engine_tb_top.sv
module dbg_burst_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'h0;
  logic [15:0] cfg_rdata;
  logic        busy;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = 16'h0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        mem_en, mem_wr;
  logic [1:0]  mem_be;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = 16'h0;
  logic        rf_rd, rf_wr;
  logic [3:0]  rf_idx;
  logic [15:0] rf_wdata;
  logic [15:0] rf_rdata = 16'h0;

  int checks = 0;
  int fails  = 0;
  int wr_acc = 0;
  int rd_acc = 0;
  bit done   = 1'b0;

  logic [15:0] mem_model [512];
  logic [15:0] rf_model  [16];

  always #4 clk = ~clk;

  dbg_burst_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .mem_en(mem_en), .mem_wr(mem_wr), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_rd(rf_rd), .rf_wr(rf_wr),
    .rf_idx(rf_idx), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  // Target models: single-cycle synchronous memory with byte enables, register file
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_wr) begin
        if (mem_be[0]) mem_model[mem_addr[9:1]][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem_model[mem_addr[9:1]][15:8] <= mem_wdata[15:8];
        wr_acc <= wr_acc + 1;
      end else begin
        mem_rdata <= mem_model[mem_addr[9:1]];
        rd_acc <= rd_acc + 1;
      end
    end
    if (rf_wr) begin
      rf_model[rf_idx] <= rf_wdata;
      wr_acc <= wr_acc + 1;
    end
    if (rf_rd) begin
      rf_rdata <= rf_model[rf_idx];
      rd_acc <= rd_acc + 1;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [15:0] val);
    @(negedge clk);
    cfg_sel = sel;
    #1 val = cfg_rdata;
  endtask

  task automatic push(input logic [15:0] val);
    logic rdy;
    @(negedge clk);
    in_valid = 1'b1; in_data = val;
    do begin
      rdy = in_ready;
      @(posedge clk);
    end while (!rdy);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop(output logic [15:0] val);
    logic vld;
    @(negedge clk);
    out_ready = 1'b1;
    do begin
      vld = out_valid;
      val = out_data;
      @(posedge clk);
    end while (!vld);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] cnt, input logic [15:0] ctl);
    cfg_write(2'd0, a);
    cfg_write(2'd2, cnt);
    cfg_write(2'd3, ctl);
  endtask

  // {select, write value, expected readback}
  localparam logic [33:0] REG_VEC [9] = '{
    {2'd0, 16'hFFFF, 16'hFFFF}, {2'd0, 16'h0000, 16'h0000},
    {2'd1, 16'hFFFF, 16'hFFFF}, {2'd1, 16'h0000, 16'h0000},
    {2'd2, 16'hFFFF, 16'hFFFF}, {2'd2, 16'h0000, 16'h0000},
    {2'd3, 16'hFFFE, 16'h000E}, {2'd3, 16'h0000, 16'h0000},
    {2'd3, 16'h000A, 16'h000A}
  };

  initial begin
    logic [15:0] v;
    int base;
    for (int i = 0; i < 512; i++) mem_model[i] = 16'h0;
    for (int i = 0; i < 16; i++) rf_model[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      cfg_read(2'(s), v);
      check("R1 reg reset", v, 16'h0);
    end
    check("R1 idle outputs", {11'b0, busy, in_ready, out_valid, mem_en, rf_wr}, 16'h0);

    // R2 register readback table
    for (int i = 0; i < 9; i++) begin
      cfg_write(REG_VEC[i][33:32], REG_VEC[i][31:16]);
      cfg_read(REG_VEC[i][33:32], v);
      check("R2 readback", v, REG_VEC[i][15:0]);
    end

    // R5 R9 word memory write burst of 5
    base = wr_acc;
    setup(16'h0200, 16'd4, 16'h0003);
    check("R4 busy after start", {15'b0, busy}, 16'h1);
    push(16'h1234); check("R5 word 0", mem_model[9'h100], 16'h1234);
    push(16'h5678); check("R5 word 1", mem_model[9'h101], 16'h5678);
    push(16'h9ABC); check("R5 word 2", mem_model[9'h102], 16'h9ABC);
    push(16'hDEF0); check("R5 word 3", mem_model[9'h103], 16'hDEF0);
    push(16'h0FED); check("R5 word 4", mem_model[9'h104], 16'h0FED);
    wait_idle();
    check("R4 R9 write count", 16'(wr_acc - base), 16'd5);
    check("R5 no overrun", mem_model[9'h105], 16'h0000);
    cfg_read(2'd0, v); check("R11 final addr", v, 16'h020A);
    cfg_read(2'd2, v); check("R11 final count", v, 16'h0000);
    cfg_read(2'd1, v); check("R11 final data", v, 16'h0FED);

    // R10 word memory read burst with a host stall on the first item
    base = rd_acc;
    setup(16'h0200, 16'd4, 16'h0001);
    repeat (6) @(negedge clk);
    check("R10 valid held", {15'b0, out_valid}, 16'h1);
    check("R10 data held", out_data, 16'h1234);
    repeat (3) @(negedge clk);
    check("R10 data still held", out_data, 16'h1234);
    pop(v); check("R5 read 0", v, 16'h1234);
    pop(v); check("R5 read 1", v, 16'h5678);
    pop(v); check("R5 read 2", v, 16'h9ABC);
    pop(v); check("R5 read 3", v, 16'hDEF0);
    pop(v); check("R5 read 4", v, 16'h0FED);
    wait_idle();
    check("R4 read count", 16'(rd_acc - base), 16'd5);

    // R6 register-file burst
    setup(16'h0005, 16'd4, 16'h0007);
    push(16'hCBA9); push(16'h8765); push(16'h4321); push(16'h0123); push(16'h4567);
    wait_idle();
    check("R6 r5", rf_model[5], 16'hCBA9);
    check("R6 r6", rf_model[6], 16'h8765);
    check("R6 r7", rf_model[7], 16'h4321);
    check("R6 r8", rf_model[8], 16'h0123);
    check("R6 r9", rf_model[9], 16'h4567);
    check("R6 r10 untouched", rf_model[10], 16'h0000);
    cfg_read(2'd0, v); check("R6 final index", v, 16'h000A);
    setup(16'h0005, 16'd4, 16'h0005);
    pop(v); check("R6 read r5", v, 16'hCBA9);
    pop(v); check("R6 read r6", v, 16'h8765);
    pop(v); check("R6 read r7", v, 16'h4321);
    pop(v); check("R6 read r8", v, 16'h0123);
    pop(v); check("R6 read r9", v, 16'h4567);
    wait_idle();

    // R7 byte memory write burst, junk in upper input byte
    setup(16'h0200, 16'd4, 16'h000B);
    push(16'hAA91); check("R7 even lane", mem_model[9'h100], 16'h1291);
    push(16'hAA82); check("R7 odd lane", mem_model[9'h100], 16'h8291);
    push(16'hAA73); check("R7 even lane 2", mem_model[9'h101], 16'h5673);
    push(16'hAA64); check("R7 odd lane 2", mem_model[9'h101], 16'h6473);
    push(16'hAA55); check("R7 even lane 3", mem_model[9'h102], 16'h9A55);
    wait_idle();
    cfg_read(2'd0, v); check("R7 final addr", v, 16'h0205);
    cfg_read(2'd1, v); check("R11 byte data", v, 16'h0055);

    // R8 byte memory read burst
    setup(16'h0200, 16'd4, 16'h0009);
    pop(v); check("R8 byte 0", v, 16'h0091);
    pop(v); check("R8 byte 1", v, 16'h0082);
    pop(v); check("R8 byte 2", v, 16'h0073);
    pop(v); check("R8 byte 3", v, 16'h0064);
    pop(v); check("R8 byte 4", v, 16'h0055);
    wait_idle();

    // R12 host writes while busy are ignored
    base = wr_acc;
    setup(16'h0300, 16'd1, 16'h0003);
    cfg_write(2'd0, 16'h1234);
    cfg_write(2'd3, 16'h0009);
    push(16'h1111); push(16'h2222);
    wait_idle();
    check("R12 write count", 16'(wr_acc - base), 16'd2);
    check("R12 item 0", mem_model[9'h180], 16'h1111);
    check("R12 item 1", mem_model[9'h181], 16'h2222);
    cfg_read(2'd0, v); check("R12 addr kept", v, 16'h0304);
    cfg_read(2'd3, v); check("R12 control kept", v, 16'h0002);
    repeat (4) @(negedge clk);
    check("R12 no restart", {15'b0, busy}, 16'h0);

    // R4 count of zero gives one access
    base = wr_acc;
    setup(16'h0210, 16'd0, 16'h0003);
    push(16'h7777);
    wait_idle();
    check("R4 single access", 16'(wr_acc - base), 16'd1);
    check("R4 single data", mem_model[9'h108], 16'h7777);
    cfg_read(2'd0, v); check("R4 single addr", v, 16'h0212);
    check("R9 ready low when idle", {15'b0, in_ready}, 16'h0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule